// File: doc/BRIEF.md
# FIFO Level Interrupt Controller

This block turns the fill levels of a write FIFO and a read FIFO into one interrupt line. Four level conditions are watched every cycle: read FIFO full, write FIFO empty, read occupancy above half of its depth, and write occupancy below half of its depth. Each condition sets its own sticky status bit. Software clears a bit by writing 1 to it, because a 1 inverts the bit. A per-source enable register and a single global enable bit decide whether the status bits reach the interrupt output.

Both FIFO occupancy counts arrive as plain inputs. The FIFO depths are parameters. Software reaches the three registers over a simple bus: a write takes effect at the next clock edge, and read data is returned in the same cycle as the read strobe. While a condition holds, its status bit is forced to 1 on every cycle. A toggle-write to that bit therefore cannot clear it until the FIFO level moves.

Top module: `fifo_level_irq`

## Requirements
- R1: While reset is asserted and directly after it, the status, enable and global enable registers read as zero and `irq` is low.
- R2: Status bit 3 is set on any clock edge at which `rd_occ` equals `RD_DEPTH`.
- R3: Status bit 2 is set on any clock edge at which `wr_occ` equals zero.
- R4: Status bit 1 is set on any clock edge at which `rd_occ` is strictly greater than `RD_DEPTH/2`.
- R5: Status bit 0 is set on any clock edge at which `wr_occ` is strictly less than `WR_DEPTH/2`.
- R6: A set status bit stays set after its condition goes away, until software toggles it.
- R7: A write to the status register (offset 0x020) inverts each of bits 3..0 whose data bit is 1. Bits whose data bit is 0 are left unchanged.
- R8: If a condition holds in the same cycle as a toggle-write to its bit, the bit ends up set.
- R9: The enable register at offset 0x028 holds one enable bit in bits 3..0, at the same positions as the status bits. It reads back what was written.
- R10: The global enable is bit 31 of the register at offset 0x01C. It reads back what was written.
- R11: `irq` is high exactly when the global enable is 1 and at least one status bit is 1 together with its enable bit.
- R12: Reserved bits read as zero and ignore writes. Unmapped offsets read as zero, and writes to them change no register. `reg_rdata` is zero when `reg_rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_occ | input | $clog2(WR_DEPTH+1) | Write FIFO occupancy count |
| rd_occ | input | $clog2(RD_DEPTH+1) | Read FIFO occupancy count |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, valid in the cycle of the read strobe |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a toggle-write that lands on a bit whose condition holds in that same cycle. In that case the set must win over the inversion. The bench keeps the read FIFO full across the write so that both events meet at one clock edge.

The bench also sweeps every pair of occupancy values of a small configuration. Each pair is held for exactly one cycle and then returned to a neutral level. The status is read afterwards, which shows both the threshold boundaries and that the bits stay set.

The interrupt function is checked over every combination of status pattern, enable pattern and global enable. The status pattern is built by toggle-writes, not by FIFO conditions.

// File: rtl/fli_pkg.sv
package fli_pkg;
   localparam int SRC_N = 4;

   typedef enum int {
      SRC_WR_LOW   = 0,
      SRC_RD_HIGH  = 1,
      SRC_WR_EMPTY = 2,
      SRC_RD_FULL  = 3
   } src_idx_e;

   function automatic int occ_width(input int depth);
      return $clog2(depth + 1);
   endfunction
endpackage

// File: rtl/fli_level_detect.sv
module fli_level_detect #(
   parameter int WR_DEPTH = 64,
   parameter int RD_DEPTH = 128,
   localparam int WOCC_W  = fli_pkg::occ_width(WR_DEPTH),
   localparam int ROCC_W  = fli_pkg::occ_width(RD_DEPTH)
) (
   input  logic [WOCC_W-1:0]        wr_occ,
   input  logic [ROCC_W-1:0]        rd_occ,
   output logic [fli_pkg::SRC_N-1:0] cond
);
   localparam logic [WOCC_W-1:0] WR_HALF_LVL = WOCC_W'(WR_DEPTH / 2);
   localparam logic [ROCC_W-1:0] RD_HALF_LVL = ROCC_W'(RD_DEPTH / 2);
   localparam logic [ROCC_W-1:0] RD_FULL_LVL = ROCC_W'(RD_DEPTH);

   always_comb begin
      cond                        = '0;
      cond[fli_pkg::SRC_WR_LOW]   = (wr_occ < WR_HALF_LVL);
      cond[fli_pkg::SRC_RD_HIGH]  = (rd_occ > RD_HALF_LVL);
      cond[fli_pkg::SRC_WR_EMPTY] = (wr_occ == '0);
      cond[fli_pkg::SRC_RD_FULL]  = (rd_occ == RD_FULL_LVL);
   end
endmodule

// File: rtl/fli_tow_status.sv
module fli_tow_status #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic         tog_we,
   input  logic [N-1:0] tog_bits,
   output logic [N-1:0] stat_q
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bit_q <= 1'b0;
         end else if (set_i[i]) begin
            bit_q <= 1'b1;
         end else if (tog_we && tog_bits[i]) begin
            bit_q <= ~bit_q;
         end
      end
      assign stat_q[i] = bit_q;
   end
endmodule

// File: rtl/fli_ctrl_reg.sv
module fli_ctrl_reg #(
   parameter int                 DATA_W = 32,
   parameter logic [DATA_W-1:0]  WMASK  = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (we) begin
         q <= wdata & WMASK;
      end
   end
endmodule

// File: rtl/fifo_level_irq.sv
module fifo_level_irq #(
   parameter int                WR_DEPTH = 64,
   parameter int                RD_DEPTH = 128,
   parameter int                DATA_W   = 32,
   parameter int                ADDR_W   = 9,
   parameter int                GIE_BIT  = 31,
   parameter logic [ADDR_W-1:0] GIE_OFS  = 'h01C,
   parameter logic [ADDR_W-1:0] STAT_OFS = 'h020,
   parameter logic [ADDR_W-1:0] EN_OFS   = 'h028,
   localparam int               WOCC_W   = fli_pkg::occ_width(WR_DEPTH),
   localparam int               ROCC_W   = fli_pkg::occ_width(RD_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WOCC_W-1:0] wr_occ,
   input  logic [ROCC_W-1:0] rd_occ,
   input  logic              reg_wr_en,
   input  logic              reg_rd_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   localparam int                SRC_N    = fli_pkg::SRC_N;
   localparam logic [DATA_W-1:0] EN_MASK  = DATA_W'((1 << SRC_N) - 1);
   localparam logic [DATA_W-1:0] GIE_MASK = DATA_W'(1) << GIE_BIT;

   // elaboration-time parameter checks
   if (WR_DEPTH < 2 || RD_DEPTH < 2) begin : g_bad_depth
      $error("fifo_level_irq: FIFO depths must be at least 2");
   end
   if (GIE_BIT >= DATA_W || SRC_N > DATA_W || GIE_BIT < SRC_N) begin : g_bad_bits
      $error("fifo_level_irq: bit positions do not fit the data width");
   end
   if (GIE_OFS == STAT_OFS || GIE_OFS == EN_OFS || STAT_OFS == EN_OFS) begin : g_bad_map
      $error("fifo_level_irq: register offsets must be distinct");
   end
   if (GIE_OFS[1:0] != 2'b00 || STAT_OFS[1:0] != 2'b00 || EN_OFS[1:0] != 2'b00) begin : g_bad_align
      $error("fifo_level_irq: register offsets must be word aligned");
   end

   logic [SRC_N-1:0]  src_cond;
   logic [SRC_N-1:0]  stat_q;
   logic [SRC_N-1:0]  stat_tog_bits;
   logic [SRC_N-1:0]  en_act;
   logic [DATA_W-1:0] en_q;
   logic [DATA_W-1:0] gie_q;
   logic              gie_act;
   logic              stat_tog_we;
   logic              en_we;
   logic              gie_we;

   // write decode
   assign stat_tog_we   = reg_wr_en && (reg_addr == STAT_OFS);
   assign en_we         = reg_wr_en && (reg_addr == EN_OFS);
   assign gie_we        = reg_wr_en && (reg_addr == GIE_OFS);
   assign stat_tog_bits = reg_wdata[SRC_N-1:0];

   fli_level_detect #(
      .WR_DEPTH(WR_DEPTH),
      .RD_DEPTH(RD_DEPTH)
   ) u_detect (
      .wr_occ(wr_occ),
      .rd_occ(rd_occ),
      .cond  (src_cond)
   );

   fli_tow_status #(
      .N(SRC_N)
   ) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (src_cond),
      .tog_we  (stat_tog_we),
      .tog_bits(stat_tog_bits),
      .stat_q  (stat_q)
   );

   fli_ctrl_reg #(
      .DATA_W(DATA_W),
      .WMASK (EN_MASK)
   ) u_enable (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (en_we),
      .wdata(reg_wdata),
      .q    (en_q)
   );

   fli_ctrl_reg #(
      .DATA_W(DATA_W),
      .WMASK (GIE_MASK)
   ) u_global (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (gie_we),
      .wdata(reg_wdata),
      .q    (gie_q)
   );

   assign en_act  = en_q[SRC_N-1:0];
   assign gie_act = gie_q[GIE_BIT];
   assign irq     = gie_act && (|(stat_q & en_act));

   // read mux, same-cycle data
   always_comb begin
      reg_rdata = '0;
      if (reg_rd_en) begin
         if (reg_addr == GIE_OFS) begin
            reg_rdata = gie_q;
         end else if (reg_addr == STAT_OFS) begin
            reg_rdata = DATA_W'(stat_q);
         end else if (reg_addr == EN_OFS) begin
            reg_rdata = en_q;
         end
      end
   end
endmodule

// File: rtl/fli_checker.sv
module fli_checker #(
   parameter int                SRC_N    = 4,
   parameter int                DATA_W   = 32,
   parameter int                ADDR_W   = 9,
   parameter logic [ADDR_W-1:0] STAT_OFS = 'h020,
   parameter logic [ADDR_W-1:0] EN_OFS   = 'h028
) (
   input logic              clk,
   input logic              rst_n,
   input logic [SRC_N-1:0]  src_cond,
   input logic [SRC_N-1:0]  stat_q,
   input logic              stat_tog_we,
   input logic [SRC_N-1:0]  stat_tog_bits,
   input logic [SRC_N-1:0]  en_act,
   input logic              gie_act,
   input logic              irq,
   input logic              reg_rd_en,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_rdata
);
   for (genvar i = 0; i < SRC_N; i++) begin : g_src
      // R8: a holding condition forces the bit set, toggle or not
      assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
         src_cond[i] |=> stat_q[i]);
      // R7: a toggle without a condition inverts the bit
      assert_toggle_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_tog_we && stat_tog_bits[i] && !src_cond[i]) |=> (stat_q[i] != $past(stat_q[i])));
      // R6: no condition and no toggle keeps the bit
      assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (!(stat_tog_we && stat_tog_bits[i]) && !src_cond[i]) |=> $stable(stat_q[i]));
   end

   assert_gie_gates_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !gie_act |-> !irq);
   assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|(stat_q & en_act)));
   assert_rsvd_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_en && (reg_addr == STAT_OFS || reg_addr == EN_OFS))
         |-> (reg_rdata[DATA_W-1:SRC_N] == '0));
   assert_idle_rdata_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd_en |-> (reg_rdata == '0));
endmodule

bind fifo_level_irq fli_checker #(
   .SRC_N   (fli_pkg::SRC_N),
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .STAT_OFS(STAT_OFS),
   .EN_OFS  (EN_OFS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .src_cond     (src_cond),
   .stat_q       (stat_q),
   .stat_tog_we  (stat_tog_we),
   .stat_tog_bits(stat_tog_bits),
   .en_act       (en_act),
   .gie_act      (gie_act),
   .irq          (irq),
   .reg_rd_en    (reg_rd_en),
   .reg_addr     (reg_addr),
   .reg_rdata    (reg_rdata)
);

// File: tb/fifo_level_irq_tb.sv
module fifo_level_irq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WD         = 8;
   localparam int RD         = 8;
   localparam int WW         = $clog2(WD + 1);
   localparam int RW         = $clog2(RD + 1);
   localparam logic [8:0] A_GIE  = 9'h01C;
   localparam logic [8:0] A_STAT = 9'h020;
   localparam logic [8:0] A_EN   = 9'h028;
   localparam logic [WW-1:0] W_NEUTRAL = WW'(WD / 2);
   localparam logic [RW-1:0] R_NEUTRAL = '0;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [WW-1:0] wr_occ;
   logic [RW-1:0] rd_occ;
   logic          reg_wr_en;
   logic          reg_rd_en;
   logic [8:0]    reg_addr;
   logic [31:0]   reg_wdata;
   logic [31:0]   reg_rdata;
   logic          irq;

   int vectors = 0;
   int fails   = 0;
   int cycles  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   fifo_level_irq #(
      .WR_DEPTH(WD),
      .RD_DEPTH(RD)
   ) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_occ   (wr_occ),
      .rd_occ   (rd_occ),
      .reg_wr_en(reg_wr_en),
      .reg_rd_en(reg_rd_en),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .irq      (irq)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [8:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1;
      reg_addr  = a;
      reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic do_read(input logic [8:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd_en = 1'b1;
      reg_addr  = a;
      #1;
      d = reg_rdata;
      reg_rd_en = 1'b0;
   endtask

   task automatic set_occ(input int w, input int r);
      @(negedge clk);
      wr_occ = WW'(w);
      rd_occ = RW'(r);
   endtask

   task automatic clear_status();
      logic [31:0] v;
      do_read(A_STAT, v);
      do_write(A_STAT, v);
   endtask

   function automatic logic [3:0] exp_cond(input int w, input int r);
      logic [3:0] e;
      e[0] = (w < WD / 2);
      e[1] = (r > RD / 2);
      e[2] = (w == 0);
      e[3] = (r == RD);
      return e;
   endfunction

   initial begin
      logic [31:0] v;
      logic [3:0]  e;
      logic [3:0]  tog_exp;
      rst_n     = 1'b0;
      wr_occ    = W_NEUTRAL;
      rd_occ    = R_NEUTRAL;
      reg_wr_en = 1'b0;
      reg_rd_en = 1'b0;
      reg_addr  = '0;
      reg_wdata = '0;
      repeat (3) @(negedge clk);

      // R1: registers in reset
      do_read(A_STAT, v); check("R1 status in reset", v, 32'h0);
      do_read(A_EN, v);   check("R1 enable in reset", v, 32'h0);
      do_read(A_GIE, v);  check("R1 gie in reset", v, 32'h0);
      check("R1 irq in reset", {31'b0, irq}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      do_read(A_STAT, v); check("R1 status after reset", v, 32'h0);
      check("R1 irq after reset", {31'b0, irq}, 32'h0);

      // R2 R3 R4 R5 R6: sweep all occupancy pairs, one cycle each
      for (int w = 0; w <= WD; w++) begin
         for (int r = 0; r <= RD; r++) begin
            set_occ(w, r);
            set_occ(WD / 2, 0);
            e = exp_cond(w, r);
            do_read(A_STAT, v);
            check("R2 read full bit", {31'b0, v[3]}, {31'b0, e[3]});
            check("R3 write empty bit", {31'b0, v[2]}, {31'b0, e[2]});
            check("R4 read above half bit", {31'b0, v[1]}, {31'b0, e[1]});
            check("R5 write below half bit", {31'b0, v[0]}, {31'b0, e[0]});
            repeat (2) @(negedge clk);
            do_read(A_STAT, v);
            check("R6 sticky after condition ends", v, {28'b0, e});
            do_write(A_STAT, v);
            do_read(A_STAT, v);
            check("R7 toggle clears set bits", v, 32'h0);
         end
      end

      // R7: toggle sweep over every mask
      tog_exp = '0;
      for (int m = 0; m < 16; m++) begin
         do_write(A_STAT, 32'(m));
         tog_exp = tog_exp ^ 4'(m);
         do_read(A_STAT, v);
         check("R7 toggle pattern", v, {28'b0, tog_exp});
      end
      do_write(A_STAT, 32'h0);
      do_read(A_STAT, v);
      check("R7 zero write no change", v, {28'b0, tog_exp});
      // R12: reserved bits of a status write are ignored
      do_write(A_STAT, 32'hFFFF_FFF0);
      do_read(A_STAT, v);
      check("R12 status reserved write ignored", v, {28'b0, tog_exp});
      clear_status();

      // R8: set wins over a same-cycle toggle
      set_occ(WD / 2, RD);
      @(negedge clk);
      do_read(A_STAT, v);
      check("R8 full held before toggle", v, 32'h0000_000A);
      do_write(A_STAT, 32'h0000_0008);
      do_read(A_STAT, v);
      check("R8 set wins over toggle", v, 32'h0000_000A);
      set_occ(WD / 2, 0);
      clear_status();
      do_read(A_STAT, v);
      check("R8 clears once condition gone", v, 32'h0);

      // R9 R10 R12: control register readback and reserved bits
      do_write(A_EN, 32'hFFFF_FFFF);
      do_read(A_EN, v);  check("R9 enable readback", v, 32'h0000_000F);
      do_write(A_EN, 32'h0000_0005);
      do_read(A_EN, v);  check("R9 enable pattern", v, 32'h0000_0005);
      do_write(A_GIE, 32'hFFFF_FFFF);
      do_read(A_GIE, v); check("R10 gie readback", v, 32'h8000_0000);
      do_write(A_GIE, 32'h7FFF_FFFF);
      do_read(A_GIE, v); check("R10 gie low bits ignored", v, 32'h0);
      do_write(9'h024, 32'hFFFF_FFFF);
      do_read(9'h024, v); check("R12 unmapped reads zero", v, 32'h0);
      do_read(A_EN, v);   check("R12 unmapped write no effect", v, 32'h0000_0005);
      do_read(A_STAT, v); check("R12 unmapped write status", v, 32'h0);
      @(negedge clk);
      reg_addr = A_EN;
      #1;
      check("R12 rdata zero without strobe", reg_rdata, 32'h0);

      // R11: irq over all status, enable and gie combinations
      for (int g = 0; g < 2; g++) begin
         for (int s = 0; s < 16; s++) begin
            for (int en = 0; en < 16; en++) begin
               clear_status();
               do_write(A_STAT, 32'(s));
               do_write(A_EN, 32'(en));
               do_write(A_GIE, (g == 1) ? 32'h8000_0000 : 32'h0);
               #1;
               check("R11 irq function", {31'b0, irq},
                     {31'b0, (g == 1) && ((s & en) != 0)});
            end
         end
      end

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule